// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

The block holds three down-counting interval timers behind a small register bus running on a 16 MHz system clock. A free-running prescaler produces strobes at one eighth, one sixteenth, one thirty-second and one sixty-fourth of that clock, which correspond to 2 MHz, 1 MHz, 500 kHz and 250 kHz. Each timer takes one of these strobes as its tick. When a running timer reaches zero it reloads from its initial-count register. If its interrupt is enabled, it also sets a sticky status bit.

The status bits are gated by their enables and then ORed into one level interrupt output. Software reads all three status bits together in the first control register. It clears a bit either by writing 0 to that bit position or by writing any value to the timer's own clear register. Live counts are read through two count registers. One returns timers 1 and 2 captured in the same cycle, and the other returns timer 3. A mode bit in the second control register decides whether every read of the timer-3 register takes a fresh capture, or whether that register holds its snapshot until the next read of the shared timer-1/2 register.

Top module: `timer_bank`

## Requirements
- R1: Each timer's 2-bit rate select sets its tick to one of four system-clock divides. 00 selects 8, 01 selects 16, 10 selects 32 and 11 selects 64. A running timer with initial count N and interrupts enabled sets its status once every (N+1) x divide cycles. The select fields sit in CTRL (offset 0x00), with timer 1 at bits [1:0], timer 2 at [3:2] and timer 3 at [5:4].
- R2: A timer counts only while its enable bit is 1 (CTRL bits 6, 7 and 8 for timers 1, 2 and 3). While the bit is 0, its count holds.
- R3: A timer whose interrupt-enable bit is 0 (CTRL bits 9, 10 and 11) never sets its status bit, and `irq` stays low.
- R4: The status bits of all three timers read together in CTRL bits [14:12], and several of them can be 1 at the same time.
- R5: A CTRL write that carries 0 in a status bit position clears that status bit. A 1 in that position leaves the status bit unchanged.
- R6: A write of any data to a timer's clear register clears that timer's status bit. The clear registers sit at offset 0x1C for timer 1, 0x20 for timer 2 and 0x24 for timer 3.
- R7: `irq` is the OR of the status bits whose interrupt-enable bits are 1. It stays high until all of those bits are cleared.
- R8: After reset, every control bit is 0, including the latch mode in CTRL2 bit 0 at offset 0x04. All counts, initial counts and status bits are also 0, and `irq` is low.
- R9: With the latch mode at 0, every read of COUNT3 (offset 0x18) returns a fresh capture of timer 3's count.
- R10: With the latch mode at 1, COUNT3 returns its held snapshot unchanged. A read of COUNT12 (offset 0x14) refreshes that snapshot.
- R11: A read of COUNT12 returns timer 1's count in bits [15:0] and timer 2's count in bits [31:16], both captured in the same cycle.
- R12: A timer that ticks at zero reloads its initial count. A write to a timer's initial-count register also loads its counter. The initial-count registers are at 0x08, 0x0C and 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | AW (6) | Byte offset of the register |
| wdata | input | 2*CNT_W (32) | Write data |
| rdata | output | 2*CNT_W (32) | Read data, registered, held between reads |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the clock edge that samples it, and read data appears one edge after the read strobe. The bench therefore drives each access on a falling edge and reads the result on the next falling edge. Interrupt periods are timed by a separate detector that stamps every rising edge of `irq` with a cycle count. Each period is taken as the difference between two such stamps, so the unknown prescaler phase at enable time cancels out. Checks that involve hold, latching or masking wait at least several tick periods of the slowest rate involved before they read, so any wrong behaviour has had time to show.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int CNT_W = 16,
  parameter int AW    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*CNT_W-1:0] wdata,
  output logic [2*CNT_W-1:0] rdata,
  output logic            irq
);
  localparam int DW = 2 * CNT_W;
  localparam logic [AW-1:0] A_CTRL  = AW'(8'h00);
  localparam logic [AW-1:0] A_CTRL2 = AW'(8'h04);
  localparam logic [AW-1:0] A_INIT  = AW'(8'h08);
  localparam logic [AW-1:0] A_CNT12 = AW'(8'h14);
  localparam logic [AW-1:0] A_CNT3  = AW'(8'h18);
  localparam logic [AW-1:0] A_CLR   = AW'(8'h1C);

  logic [5:0]            pre;
  logic [3:0]            tick;
  logic [2:0][1:0]       sel;
  logic [2:0]            en, ie, st, tk, expire, clr, init_wr;
  logic                  mode;
  logic [2:0][CNT_W-1:0] init, cnt;
  logic [CNT_W-1:0]      snap3;

  assign tick = {pre == 6'd63, pre[4:0] == 5'd31, pre[3:0] == 4'd15, pre[2:0] == 3'd7};
  assign irq  = |(st & ie);

  wire ctrl_wr = wr_en && addr == A_CTRL;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      tk[i]      = en[i] && tick[sel[i]];
      expire[i]  = tk[i] && cnt[i] == '0;
      init_wr[i] = wr_en && addr == A_INIT + AW'(4 * i);
      clr[i]     = (wr_en && addr == A_CLR + AW'(4 * i)) || (ctrl_wr && !wdata[12 + i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      sel   <= '0;
      en    <= '0;
      ie    <= '0;
      st    <= '0;
      mode  <= 1'b0;
      init  <= '0;
      cnt   <= '0;
      snap3 <= '0;
      rdata <= '0;
    end else begin
      pre <= pre + 6'd1;
      if (ctrl_wr) begin
        sel <= wdata[5:0];
        en  <= wdata[8:6];
        ie  <= wdata[11:9];
      end
      if (wr_en && addr == A_CTRL2) mode <= wdata[0];
      for (int i = 0; i < 3; i++) begin
        if (init_wr[i]) begin
          init[i] <= wdata[CNT_W-1:0];
          cnt[i]  <= wdata[CNT_W-1:0];
        end else if (tk[i]) begin
          cnt[i] <= (cnt[i] == '0) ? init[i] : cnt[i] - 1'b1;
        end
        st[i] <= (st[i] && !clr[i]) || (expire[i] && ie[i]);
      end
      if (rd_en) begin
        rdata <= '0;
        if (addr == A_CTRL) rdata <= DW'({st, ie, en, sel});
        if (addr == A_CTRL2) rdata <= DW'(mode);
        for (int i = 0; i < 3; i++)
          if (addr == A_INIT + AW'(4 * i)) rdata <= DW'(init[i]);
        if (addr == A_CNT12) begin
          rdata <= {cnt[1], cnt[0]};
          snap3 <= cnt[2];
        end
        if (addr == A_CNT3) begin
          if (mode) rdata <= DW'(snap3);
          else begin
            rdata <= DW'(cnt[2]);
            snap3 <= cnt[2];
          end
        end
      end
    end
  end
endmodule

module timer_bank_chk #(
  parameter int CNT_W = 16,
  parameter int AW    = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [AW-1:0]         addr,
  input logic [2*CNT_W-1:0]    wdata,
  input logic                  irq,
  input logic [2:0]            en,
  input logic [2:0]            ie,
  input logic [2:0]            st,
  input logic [2:0]            tk,
  input logic [2:0]            expire,
  input logic                  mode,
  input logic [2:0][CNT_W-1:0] cnt,
  input logic [2:0][CNT_W-1:0] init,
  input logic [CNT_W-1:0]      snap3
);
  wire wr_init0 = wr_en && addr == AW'(8'h08);
  wire wr_clr0  = wr_en && addr == AW'(8'h1C);
  wire wr_ctrl  = wr_en && addr == AW'(8'h00);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] && !wr_init0) |=> $stable(cnt[0]));
  p_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tk[0] && cnt[0] == '0 && !wr_init0) |=> cnt[0] == $past(init[0]));
  p_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie[0] && !st[0]) |=> !st[0]);
  p_w1_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] && !wr_clr0 && !(wr_ctrl && !wdata[12])) |=> st[0]);
  p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr0 && !(expire[0] && ie[0])) |=> !st[0]);
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == 3'b000) |-> !irq);
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !(rd_en && addr == AW'(8'h14))) |=> $stable(snap3));
endmodule

bind timer_bank timer_bank_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .irq(irq), .en(en), .ie(ie), .st(st), .tk(tk),
  .expire(expire), .mode(mode), .cnt(cnt), .init(init), .snap3(snap3)
);

// File: tb/timer_bank_bench.sv
module timer_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nrise = 0;
  int rise_at [0:15];
  logic irq_q = 1'b0;

  timer_bank u_timer_bank (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (irq && !irq_q && nrise < 16) begin
      rise_at[nrise] = cyc;
      nrise++;
    end
    irq_q = irq;
  end

  localparam int VSEL [4] = '{0, 1, 2, 3};
  localparam int VINI [4] = '{5, 3, 2, 1};
  localparam int VPER [4] = '{48, 64, 96, 128};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] ctl(logic [5:0] s, logic [2:0] e, logic [2:0] i, logic [2:0] keep);
    return {17'd0, keep, i, e, s};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, a, b, c;
    idle(5);
    rst_n = 1'b1;
    chk("R8 irq after reset", 32'(irq), 0);
    rd(6'h00, d); chk("R8 CTRL reset", d, 0);
    rd(6'h04, d); chk("R8 CTRL2 reset", d, 0);
    rd(6'h14, d); chk("R8 COUNT12 reset", d, 0);

    for (int v = 0; v < 4; v++) begin
      int base;
      wr(6'h00, ctl(6'd0, 3'b000, 3'b000, 3'b000));
      wr(6'h08, 32'(VINI[v]));
      base = nrise;
      wr(6'h00, ctl(6'(VSEL[v]), 3'b001, 3'b001, 3'b111));
      while (nrise < base + 1) @(negedge clk);
      wr(6'h1C, 32'h0);
      while (nrise < base + 2) @(negedge clk);
      chk($sformatf("R1 period sel=%0d", VSEL[v]), 32'(rise_at[base+1] - rise_at[base]), 32'(VPER[v]));
    end

    wr(6'h00, ctl(6'd0, 3'b000, 3'b000, 3'b000));
    wr(6'h08, 32'd100);
    rd(6'h14, d); chk("R12 init write loads count", d & 32'hFFFF, 100);
    idle(200);
    rd(6'h14, d); chk("R2 disabled count holds", d & 32'hFFFF, 100);

    wr(6'h08, 32'd1);
    wr(6'h00, ctl(6'd0, 3'b001, 3'b000, 3'b111));
    idle(100);
    rd(6'h00, d); chk("R3 no status without enable", (d >> 12) & 7, 0);
    chk("R3 irq low", 32'(irq), 0);

    wr(6'h00, ctl(6'd0, 3'b000, 3'b000, 3'b000));
    wr(6'h08, 32'd1);
    wr(6'h0C, 32'd1);
    wr(6'h00, ctl(6'd0, 3'b011, 3'b011, 3'b111));
    idle(100);
    wr(6'h00, ctl(6'd0, 3'b000, 3'b011, 3'b111));
    rd(6'h00, d); chk("R4 two status bits", (d >> 12) & 7, 3);
    chk("R7 irq high", 32'(irq), 1);
    wr(6'h00, ctl(6'd0, 3'b000, 3'b011, 3'b110));
    rd(6'h00, d); chk("R5 write0 clears, write1 keeps", (d >> 12) & 7, 2);
    chk("R7 irq held by remaining bit", 32'(irq), 1);
    wr(6'h20, 32'h0);
    rd(6'h00, d); chk("R6 clear register", (d >> 12) & 7, 0);
    chk("R7 irq low after all cleared", 32'(irq), 0);

    wr(6'h10, 32'd1000);
    wr(6'h00, ctl(6'd0, 3'b100, 3'b000, 3'b111));
    rd(6'h18, a);
    idle(40);
    rd(6'h18, b);
    chk("R9 fresh capture moves", 32'(b < a), 1);
    wr(6'h04, 32'h1);
    rd(6'h18, c); chk("R10 held snapshot after mode change", c, b);
    idle(40);
    rd(6'h18, d); chk("R10 snapshot stays", d, c);
    rd(6'h14, a);
    rd(6'h18, d); chk("R10 COUNT12 read refreshes", 32'(d < c), 1);

    wr(6'h00, ctl(6'd0, 3'b000, 3'b000, 3'b111));
    wr(6'h08, 32'd500);
    wr(6'h0C, 32'd500);
    wr(6'h00, ctl(6'b000101, 3'b011, 3'b000, 3'b111));
    idle(50);
    rd(6'h14, d);
    chk("R11 both halves equal", d >> 16, d & 32'hFFFF);
    chk("R11 counts moved", 32'((d & 32'hFFFF) < 500), 1);

    finish_run();
  end
endmodule